// File: doc/BRIEF.md
# Half-Duty Odd Clock Divider (divide by three)

The block divides an input clock by three and delivers an output clock whose high and low times are equal, each one and a half input periods long. It is built from three storage stages. Each stage can capture on either the rising or the falling input edge, and the captured edge is picked at run time by a select level taken from another stage. The stage outputs form a six-step rotating code, so no gating or combining logic is needed after the stages to reach the even duty.

The divided clock is the first stage's output. All three stage outputs are also brought out as a phase bus. Each stage lags the one before it by half an input period, which is sixty degrees of the output period. An active-low asynchronous reset clears every stage. The sequence then restarts on the first falling input edge after release.

Top module: `odd_half_duty_div`

## Requirements
- R1: While `rst_n` is low, `phase` reads 3'b000 and `clk_div` reads 0. This holds from the moment reset is asserted, with no clock edge needed.
- R2: Out of reset, `phase` (bit 0 = stage one, bit 2 = stage three) steps through 000, 001, 011, 111, 110, 100 and then repeats. It makes one step per input edge at which a move is due.
- R3: Steps leaving 000, 011 and 110 occur only on falling input edges. Steps leaving 001, 111 and 100 occur only on rising input edges. At every other edge the phase bus holds.
- R4: `clk_div` follows stage one. Each high pulse and each low pulse lasts exactly three input half-periods.
- R5: A rising edge of stage two comes exactly half an input period after the rising edge of stage one. A rising edge of stage three comes exactly half an input period after that of stage two.
- R6: At most one stage changes at any input edge, and the codes 010 and 101 never appear.
- R7: After reset release, the first rising edge of `clk_div` falls on the first falling input edge, which is well within two output periods.
- R8: Asserting reset in the middle of the sequence returns `phase` to 000 at once, from any step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | output | 1 | Divided clock, input frequency over three, even duty |
| phase | output | 3 | Stage outputs, each half an input period behind the previous |

## Verification
The stepping properties assume that `rst_n` changes away from input clock edges. They also assume that the clock runs with an even duty, so that rising and falling edges alternate at equal spacing. The stimulus moves reset only half a nanosecond after an edge of either polarity. It picks the polarity, the run length and the hold time at random from a fixed seed. Directed cases cover a release after each edge type and a reset dropped in the middle of a high pulse.

// File: rtl/odd_half_duty_div.sv
`timescale 1ns/1ps
module odd_half_duty_div (
  input  logic       clk_in,
  input  logic       rst_n,
  output logic       clk_div,
  output logic [2:0] phase
);
  localparam int STAGES = 3;

  logic [STAGES-1:0] rise_q, fall_q;
  logic [STAGES-1:0] nxt, on_rise;

  assign phase = rise_q ^ fall_q;

  assign nxt[0] = ~phase[2];
  assign nxt[1] =  phase[0];
  assign nxt[2] =  phase[1];

  assign on_rise[0] =  phase[1];
  assign on_rise[1] = ~phase[2];
  assign on_rise[2] = ~phase[0];

  always_ff @(posedge clk_in or negedge rst_n)
    if (!rst_n) rise_q <= '0;
    else for (int i = 0; i < STAGES; i++)
      if (on_rise[i]) rise_q[i] <= nxt[i] ^ fall_q[i];

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) fall_q <= '0;
    else for (int i = 0; i < STAGES; i++)
      if (!on_rise[i]) fall_q[i] <= nxt[i] ^ rise_q[i];

  assign clk_div = phase[0];

  AST_NO_SPLIT_POS: assert property (@(posedge clk_in) disable iff (!rst_n)
    phase != 3'b010 && phase != 3'b101); // R6
  AST_NO_SPLIT_NEG: assert property (@(negedge clk_in) disable iff (!rst_n)
    phase != 3'b010 && phase != 3'b101); // R6
  AST_POS_STEP_A: assert property (@(posedge clk_in) disable iff (!rst_n)
    phase == 3'b001 |=> phase == 3'b111); // R3
  AST_POS_STEP_B: assert property (@(posedge clk_in) disable iff (!rst_n)
    phase == 3'b111 |=> phase == 3'b100); // R3
  AST_POS_STEP_C: assert property (@(posedge clk_in) disable iff (!rst_n)
    phase == 3'b100 |=> phase == 3'b001); // R3
  AST_NEG_STEP_A: assert property (@(negedge clk_in) disable iff (!rst_n)
    phase == 3'b000 |=> phase == 3'b011); // R2
  AST_NEG_STEP_B: assert property (@(negedge clk_in) disable iff (!rst_n)
    phase == 3'b011 |=> phase == 3'b110); // R2
  AST_NEG_STEP_C: assert property (@(negedge clk_in) disable iff (!rst_n)
    phase == 3'b110 |=> phase == 3'b000); // R2
endmodule

// File: tb/test_odd_half_duty_div.sv
`timescale 1ns/1ps
module test_odd_half_duty_div;
  localparam real HALF = 2.5;

  logic clk_in = 1'b0;
  logic rst_n  = 1'b1;
  logic clk_div;
  logic [2:0] phase;

  int checks = 0, failures = 0;
  int idx = 0;
  bit moved_due = 0;
  bit have_prev = 0;
  logic [2:0] prev_ph = '0;
  bit fall_ok = 0, rise_ok = 0, s1_ok = 0, s2_ok = 0, first_pending = 0;
  realtime t_fall = 0, t_rise = 0, t_s1 = 0, t_s2 = 0, t_rel = 0, exp_delay = 0;

  odd_half_duty_div i_odd_half_duty_div (
    .clk_in(clk_in), .rst_n(rst_n), .clk_div(clk_div), .phase(phase));

  always #(HALF) clk_in = ~clk_in;

  function automatic logic [2:0] code_of(int k);
    case (k)
      0: return 3'b000; 1: return 3'b001; 2: return 3'b011;
      3: return 3'b111; 4: return 3'b110; default: return 3'b100;
    endcase
  endfunction

  function automatic bit due_on(int k, bit rising);
    return rising == bit'(k % 2);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $realtime);
    end
  endtask

  always @(negedge rst_n) begin
    idx = 0; have_prev = 0;
    fall_ok = 0; rise_ok = 0; s1_ok = 0; s2_ok = 0; first_pending = 0;
  end

  always @(posedge clk_in or negedge clk_in) begin
    if (!rst_n) begin idx = 0; moved_due = 0; end
    else begin
      moved_due = due_on(idx, clk_in);
      if (moved_due) idx = (idx + 1) % 6;
    end
  end

  always @(posedge clk_in or negedge clk_in) begin
    #1.25;
    if (!rst_n) begin
      chk(phase == 3'b000, "R1", phase, 0);
      chk(clk_div == 1'b0, "R1", clk_div, 0);
    end else begin
      chk(phase == code_of(idx), "R2", phase, code_of(idx));
      if (have_prev) begin
        chk((phase != prev_ph) == moved_due, "R3", phase != prev_ph, moved_due);
        chk($countones(phase ^ prev_ph) <= 1, "R6", $countones(phase ^ prev_ph), 1);
      end
      chk(phase != 3'b010 && phase != 3'b101, "R6", phase, code_of(idx));
      prev_ph = phase; have_prev = 1;
    end
  end

  always @(posedge clk_div) begin
    if (rst_n) begin
      if (fall_ok) chk($realtime - t_fall == 3*HALF, "R4", int'(($realtime - t_fall)*100), int'(3*HALF*100));
      if (first_pending) begin
        chk($realtime - t_rel == exp_delay, "R7", int'(($realtime - t_rel)*100), int'(exp_delay*100));
        chk($realtime - t_rel <= 6*2*HALF, "R7", int'(($realtime - t_rel)*100), int'(12*HALF*100));
        first_pending = 0;
      end
      t_rise = $realtime; rise_ok = 1;
      t_s1 = $realtime; s1_ok = 1;
    end
  end

  always @(negedge clk_div) begin
    if (rst_n) begin
      if (rise_ok) chk($realtime - t_rise == 3*HALF, "R4", int'(($realtime - t_rise)*100), int'(3*HALF*100));
      t_fall = $realtime; fall_ok = 1;
    end
  end

  always @(posedge phase[1]) begin
    if (rst_n && s1_ok) begin
      chk($realtime - t_s1 == HALF, "R5", int'(($realtime - t_s1)*100), int'(HALF*100));
      t_s2 = $realtime; s2_ok = 1;
    end
  end

  always @(posedge phase[2]) begin
    if (rst_n && s2_ok)
      chk($realtime - t_s2 == HALF, "R5", int'(($realtime - t_s2)*100), int'(HALF*100));
  end

  task automatic wait_edge(bit rising);
    if (rising) @(posedge clk_in); else @(negedge clk_in);
    #0.5;
  endtask

  task automatic release_after(bit rising);
    wait_edge(rising);
    rst_n = 1'b1;
    t_rel = $realtime;
    exp_delay = rising ? (HALF - 0.5) : (2*HALF - 0.5);
    first_pending = 1;
  endtask

  task automatic apply_reset(bit rising, int hold);
    wait_edge(rising);
    rst_n = 1'b0;
    #0.1;
    chk(phase == 3'b000, "R8", phase, 0);
    chk(clk_div == 1'b0, "R1", clk_div, 0);
    repeat (hold) @(posedge clk_in);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk_in);
    release_after(1'b1);
    repeat (20) @(posedge clk_in);
    apply_reset(1'b0, 2);
    release_after(1'b0);
    repeat (15) @(posedge clk_in);
    @(posedge clk_div);
    #3.0;
    rst_n = 1'b0;
    #0.1;
    chk(phase == 3'b000 && clk_div == 1'b0, "R8", phase, 0);
    repeat (2) @(posedge clk_in);
    release_after(1'b1);
    for (int n = 0; n < 60; n++) begin
      repeat ($urandom_range(4, 60)) @(posedge clk_in);
      apply_reset(bit'($urandom_range(0, 1)), $urandom_range(1, 3));
      release_after(bit'($urandom_range(0, 1)));
    end
    repeat (30) @(posedge clk_in);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(2*HALF*150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule